// File: doc/BRIEF.md
# Timer Clock Source Selector

This block decides which event advances a 16-bit timer counter. The counter can step on every system clock. It can instead step on qualified edges of one of two timer input pins, or on rising edges of an external trigger pin. Every path stays in the single system-clock domain: an external "clock" is a one-cycle enable, `clk_en`, and never a real clock.

Each pin first passes through a programmable digital glitch filter. The second timer input can be inverted before its filter. An edge detector follows the filter, and a trigger multiplexer then picks the event that feeds the counter.

The source is tracked by a small state machine. Its states are `SRC_OFF`, `SRC_INT`, `SRC_EXT1` and `SRC_EXT2`. On every clock it moves to the state named by the current mode controls, with this priority:
- The external clock enable high leads to `SRC_EXT2`.
- Otherwise, mode code 000 leads to `SRC_INT`.
- Otherwise, mode code 111 leads to `SRC_EXT1`.
- Any other code leads to `SRC_OFF`.

Any state can reach any other in one clock, so a change of the controls takes effect one clock later.

Each filter has two states, `FLT_STEADY` and `FLT_QUAL`. A filter stays in `FLT_STEADY` while its input matches its output. It enters `FLT_QUAL` when the input differs and the code is nonzero. It returns to `FLT_STEADY` in two cases: the input goes back to the output value, or the input has been stable long enough and the output takes the new value.

Top module: `tmr_clk_sel`

## Requirements
- R1: After reset, `count` is 0 and `clk_en` is 0.
- R2: With `sms`=000 and `ece`=0, the internal source is selected one clock after the controls are applied. The counter then steps on every clock while `cen`=1.
- R3: While `cen`=0, `count` never changes without `ug`, whatever the source, and `clk_en` is 0.
- R4: With `dir`=0 the counter adds one per tick, and with `dir`=1 it subtracts one. It wraps modulo 2^16, so 0xFFFF goes to 0 upward and 0 goes to 0xFFFF downward.
- R5: `ug` high at a clock edge loads 0 when `dir`=0, or 0xFFFF when `dir`=1, on that same edge. This load takes priority over any tick.
- R6: With `sms`=111, `ece`=0 and `ts`=101, the counter steps once for each rising edge of filtered input 1.
- R7: With `sms`=111, `ece`=0 and `ts`=100, the counter steps on both rising and falling edges of filtered input 1.
- R8: With `sms`=111, `ece`=0 and `ts`=110, the counter steps on rising edges of filtered input 2. When `ti2_pol`=1 the pin is inverted before the filter, so falling pin edges count.
- R9: With `ece`=1, the counter steps on rising edges of the filtered external trigger, whatever `sms` and `ts` hold. With `ece`=0, `sms`=111 and `ts`=111, the same edges count.
- R10: With filter code N, the filtered level takes a new pin value only after that value has been sampled on N+1 consecutive clocks. Code 0 passes every sample. A shorter excursion is ignored. The counter step follows one clock after the level changes.
- R11: With `ece`=0, a mode code other than 000 and 111 gives no ticks. With `sms`=111, a trigger code from 000 to 011 gives no ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cen | input | 1 | Counter enable |
| dir | input | 1 | Count direction, 0 up, 1 down |
| ug | input | 1 | One-cycle re-initialise request |
| sms | input | 3 | Mode code: 000 internal, 111 external edge mode |
| ts | input | 3 | Trigger code: 100 input-1 both edges, 101 input 1, 110 input 2, 111 external trigger |
| ece | input | 1 | External trigger clock enable, highest priority |
| ti2_pol | input | 1 | Inverts input 2 before its filter |
| ti1_flt | input | 4 | Filter code for input 1 |
| ti2_flt | input | 4 | Filter code for input 2 |
| etr_flt | input | 4 | Filter code for the external trigger |
| ti1_in | input | 1 | Timer input 1, already synchronised |
| ti2_in | input | 1 | Timer input 2, already synchronised |
| etr_in | input | 1 | External trigger pin, already synchronised |
| clk_en | output | 1 | Tick to the counter, gated by `cen` |
| count | output | 16 | Counter value |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and 4-bit filter codes. With 16 bits, both wrap directions can be reached directly by using `ug` to preload 0 or 0xFFFF and then reversing `dir`. With 4-bit codes, filter code 3 can be tried with pulses one clock shorter than the qualifying window and exactly as long as it. A behavioural model updated on every clock tracks how each control change and each filtered edge travels to `count` and `clk_en`.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'd0,
        SRC_INT  = 2'd1,
        SRC_EXT1 = 2'd2,
        SRC_EXT2 = 2'd3
    } src_e;

    typedef enum logic {
        FLT_STEADY = 1'b0,
        FLT_QUAL   = 1'b1
    } flt_e;

    localparam logic [2:0] SMS_INTERNAL = 3'b000;
    localparam logic [2:0] SMS_EDGE     = 3'b111;

    localparam logic [2:0] TS_IN1_BOTH  = 3'b100;
    localparam logic [2:0] TS_IN1_FILT  = 3'b101;
    localparam logic [2:0] TS_IN2_FILT  = 3'b110;
    localparam logic [2:0] TS_TRIG_FILT = 3'b111;

    localparam int NUM_PINS = 3;

endpackage

// File: rtl/tcs_in_filter.sv
module tcs_in_filter
    import tcs_pkg::*;
#(
    parameter int FLT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [FLT_W-1:0] code,
    output logic             level,
    output logic             level_d
);

    flt_e             state_q, state_n;
    logic [FLT_W-1:0] run_q, run_n;
    logic             level_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_STEADY;
            run_q   <= '0;
            level   <= 1'b0;
            level_d <= 1'b0;
        end else begin
            state_q <= state_n;
            run_q   <= run_n;
            level   <= level_n;
            level_d <= level;
        end
    end

    // next state and output value
    always_comb begin
        state_n = state_q;
        run_n   = run_q;
        level_n = level;
        unique case (state_q)
            FLT_STEADY: begin
                if (din != level) begin
                    if (code == '0) begin
                        level_n = din;
                    end else begin
                        state_n = FLT_QUAL;
                        run_n   = {{(FLT_W-1){1'b0}}, 1'b1};
                    end
                end
            end
            FLT_QUAL: begin
                if (din == level) begin
                    state_n = FLT_STEADY;
                    run_n   = '0;
                end else if (run_q >= code) begin
                    level_n = din;
                    state_n = FLT_STEADY;
                    run_n   = '0;
                end else begin
                    run_n = run_q + 1'b1;
                end
            end
        endcase
    end

    AST_FILT_FOLLOWS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> (level == $past(din))); // R10

    AST_FILT_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(code) == '0 && $past(state_q) == FLT_STEADY) |-> (level == $past(din))); // R10

endmodule

// File: rtl/tcs_ckgen.sv
module tcs_ckgen
    import tcs_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          sms,
    input  logic [2:0]          ts,
    input  logic                ece,
    input  logic [NUM_PINS-1:0] lvl,
    input  logic [NUM_PINS-1:0] lvl_d,
    output logic                tick
);

    src_e                state_q, state_n;
    logic [NUM_PINS-1:0] rise;
    logic                in1_fall;
    logic                trig_edge;

    assign rise     = lvl & ~lvl_d;
    assign in1_fall = ~lvl[0] & lvl_d[0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SRC_OFF;
        else        state_q <= state_n;
    end

    // transitions: any state to the one named by the controls
    always_comb begin
        if (ece)                       state_n = SRC_EXT2;
        else if (sms == SMS_INTERNAL)  state_n = SRC_INT;
        else if (sms == SMS_EDGE)      state_n = SRC_EXT1;
        else                           state_n = SRC_OFF;
    end

    // trigger multiplexer
    always_comb begin
        unique case (ts)
            TS_IN1_BOTH:  trig_edge = rise[0] | in1_fall;
            TS_IN1_FILT:  trig_edge = rise[0];
            TS_IN2_FILT:  trig_edge = rise[1];
            TS_TRIG_FILT: trig_edge = rise[2];
            default:      trig_edge = 1'b0;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            SRC_OFF:  tick = 1'b0;
            SRC_INT:  tick = 1'b1;
            SRC_EXT1: tick = trig_edge;
            SRC_EXT2: tick = rise[2];
        endcase
    end

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SRC_OFF) |-> !tick); // R11

    AST_ECE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ece) |-> (state_q == SRC_EXT2)); // R9

endmodule

// File: rtl/tcs_counter.sv
module tcs_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ug,
    input  logic             cen,
    input  logic             dir,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (ug)            cnt <= dir ? TOP : '0;
        else if (cen && tick)   cnt <= dir ? cnt - 1'b1 : cnt + 1'b1;
    end

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ug && !cen) |=> $stable(cnt)); // R3

    AST_UG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ug |=> (cnt == ($past(dir) ? TOP : '0))); // R5

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ug && cen && tick) |=>
        (cnt == ($past(dir) ? $past(cnt) - 1'b1 : $past(cnt) + 1'b1))); // R4

endmodule

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel
    import tcs_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int FLT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cen,
    input  logic             dir,
    input  logic             ug,
    input  logic [2:0]       sms,
    input  logic [2:0]       ts,
    input  logic             ece,
    input  logic             ti2_pol,
    input  logic [FLT_W-1:0] ti1_flt,
    input  logic [FLT_W-1:0] ti2_flt,
    input  logic [FLT_W-1:0] etr_flt,
    input  logic             ti1_in,
    input  logic             ti2_in,
    input  logic             etr_in,
    output logic             clk_en,
    output logic [CNT_W-1:0] count
);

    logic [NUM_PINS-1:0] raw;
    logic [FLT_W-1:0]    codes [NUM_PINS];
    logic [NUM_PINS-1:0] lvl;
    logic [NUM_PINS-1:0] lvl_d;
    logic                tick;

    assign raw      = {etr_in, ti2_in ^ ti2_pol, ti1_in};
    assign codes[0] = ti1_flt;
    assign codes[1] = ti2_flt;
    assign codes[2] = etr_flt;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        tcs_in_filter #(.FLT_W(FLT_W)) u_flt (
            .clk     (clk),
            .rst_n   (rst_n),
            .din     (raw[i]),
            .code    (codes[i]),
            .level   (lvl[i]),
            .level_d (lvl_d[i])
        );
    end

    tcs_ckgen u_ckgen (
        .clk   (clk),
        .rst_n (rst_n),
        .sms   (sms),
        .ts    (ts),
        .ece   (ece),
        .lvl   (lvl),
        .lvl_d (lvl_d),
        .tick  (tick)
    );

    assign clk_en = tick & cen;

    tcs_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .ug    (ug),
        .cen   (cen),
        .dir   (dir),
        .tick  (tick),
        .cnt   (count)
    );

    AST_ECE_ONLY_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ece) && !(lvl[2] && !lvl_d[2])) |-> !clk_en); // R9

endmodule

// File: tb/tb_tmr_clk_sel.sv
module tb_tmr_clk_sel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cen = 0, dir = 0, ug = 0, ece = 0, ti2_pol = 0;
    logic [2:0]  sms = 3'b010, ts = 3'b000;
    logic [3:0]  ti1_flt = 0, ti2_flt = 0, etr_flt = 0;
    logic        ti1_in = 0, ti2_in = 0, etr_in = 0;
    logic        clk_en;
    logic [15:0] count;

    tmr_clk_sel dut (
        .clk(clk), .rst_n(rst_n), .cen(cen), .dir(dir), .ug(ug),
        .sms(sms), .ts(ts), .ece(ece), .ti2_pol(ti2_pol),
        .ti1_flt(ti1_flt), .ti2_flt(ti2_flt), .etr_flt(etr_flt),
        .ti1_in(ti1_in), .ti2_in(ti2_in), .etr_in(etr_in),
        .clk_en(clk_en), .count(count)
    );

    always #10 clk = ~clk; // 50 MHz

    int    n_checks = 0;
    int    n_fail   = 0;
    string tag      = "R1";
    bit    done     = 0;

    // behavioural reference
    int m_lvl [3];
    int m_prv [3];
    int m_run [3];
    int m_src;     // 0 off, 1 internal, 2 edge mode, 3 trigger clock
    int m_cnt;

    task automatic check(input string t, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", t, what, act, exp, $time);
        end
    endtask

    function automatic int model_tick();
        int r0, r1, r2, f0;
        r0 = (m_lvl[0] == 1 && m_prv[0] == 0) ? 1 : 0;
        r1 = (m_lvl[1] == 1 && m_prv[1] == 0) ? 1 : 0;
        r2 = (m_lvl[2] == 1 && m_prv[2] == 0) ? 1 : 0;
        f0 = (m_lvl[0] == 0 && m_prv[0] == 1) ? 1 : 0;
        if (m_src == 1) return 1;
        if (m_src == 3) return r2;
        if (m_src == 2) begin
            if (ts == 3'b100) return (r0 | f0);
            if (ts == 3'b101) return r0;
            if (ts == 3'b110) return r1;
            if (ts == 3'b111) return r2;
        end
        return 0;
    endfunction

    always @(posedge clk) begin
        int t;
        int pin [3];
        int cd [3];
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_lvl[i] = 0; m_prv[i] = 0; m_run[i] = 0;
            end
            m_src = 0;
            m_cnt = 0;
        end else begin
            t = model_tick();
            if (ug)             m_cnt = dir ? 16'hFFFF : 0;
            else if (cen && t == 1)
                m_cnt = dir ? ((m_cnt + 65535) % 65536) : ((m_cnt + 1) % 65536);
            pin[0] = int'(ti1_in); pin[1] = int'(ti2_in ^ ti2_pol); pin[2] = int'(etr_in);
            cd[0] = int'(ti1_flt); cd[1] = int'(ti2_flt); cd[2] = int'(etr_flt);
            for (int i = 0; i < 3; i++) begin
                m_prv[i] = m_lvl[i];
                if (pin[i] != m_lvl[i]) begin
                    if (m_run[i] >= cd[i]) begin
                        m_lvl[i] = pin[i];
                        m_run[i] = 0;
                    end else begin
                        m_run[i]++;
                    end
                end else begin
                    m_run[i] = 0;
                end
            end
            if (ece)                m_src = 3;
            else if (sms == 3'b000) m_src = 1;
            else if (sms == 3'b111) m_src = 2;
            else                    m_src = 0;
        end
        #5;
        if (rst_n && !done) begin
            check(tag, int'(count), m_cnt, "count vs model");
            check(tag, int'(clk_en), (cen && model_tick() == 1) ? 1 : 0, "clk_en vs model");
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int which, input int hi, input int lo);
        if (which == 0) ti1_in = 1; else if (which == 1) ti2_in = 1; else etr_in = 1;
        cyc(hi);
        if (which == 0) ti1_in = 0; else if (which == 1) ti2_in = 0; else etr_in = 0;
        cyc(lo);
    endtask

    task automatic finish_up();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        int c0;
        cyc(3);
        tag = "R1";
        check("R1", int'(count), 0, "count after reset");
        check("R1", int'(clk_en), 0, "clk_en after reset");
        rst_n = 1;
        cyc(2);
        check("R1", int'(count), 0, "count idle after reset");

        // internal clock
        tag = "R2";
        sms = 3'b000; cen = 1;
        cyc(3);
        c0 = int'(count);
        cyc(5);
        check("R2", int'(count), c0 + 5, "internal count over 5 clocks");

        // enable off
        tag = "R3";
        cen = 0;
        cyc(1);
        c0 = int'(count);
        cyc(6);
        check("R3", int'(count), c0, "hold while cen=0");
        check("R3", int'(clk_en), 0, "clk_en while cen=0");

        // re-initialise and wrap
        tag = "R5";
        cen = 1; ug = 1; dir = 0;
        cyc(1);
        check("R5", int'(count), 0, "ug load up");
        tag = "R4";
        ug = 0; dir = 1;
        cyc(1);
        check("R4", int'(count), 16'hFFFF, "wrap down");
        cyc(2);
        check("R4", int'(count), 16'hFFFD, "down step");
        tag = "R5";
        ug = 1; dir = 1;
        cyc(1);
        check("R5", int'(count), 16'hFFFF, "ug load down");
        tag = "R4";
        ug = 0; dir = 0;
        cyc(1);
        check("R4", int'(count), 0, "wrap up");

        // edge mode on input 1, rising edges
        tag = "R6";
        sms = 3'b111; ts = 3'b101;
        cyc(3);
        c0 = int'(count);
        for (int k = 0; k < 4; k++) pulse(0, 3, 3);
        cyc(3);
        check("R6", int'(count), c0 + 4, "input-1 rising edges");

        tag = "R3";
        cen = 0;
        c0 = int'(count);
        for (int k = 0; k < 2; k++) pulse(0, 3, 3);
        cyc(3);
        check("R3", int'(count), c0, "edges ignored while cen=0");
        cen = 1;

        // both edges
        tag = "R7";
        ts = 3'b100;
        cyc(2);
        c0 = int'(count);
        for (int k = 0; k < 3; k++) pulse(0, 4, 4);
        cyc(3);
        check("R7", int'(count), c0 + 6, "input-1 both edges");

        // input 2, polarity
        tag = "R8";
        ts = 3'b110; ti2_pol = 0;
        cyc(2);
        c0 = int'(count);
        for (int k = 0; k < 3; k++) pulse(1, 3, 3);
        cyc(3);
        check("R8", int'(count), c0 + 3, "input-2 rising, no inversion");
        cen = 0;
        ti2_pol = 1;
        cyc(4);
        cen = 1;
        cyc(1);
        c0 = int'(count);
        ti2_in = 1;
        cyc(4);
        check("R8", int'(count), c0, "inverted: pin rise ignored");
        ti2_in = 0;
        cyc(4);
        check("R8", int'(count), c0 + 1, "inverted: pin fall counts");
        for (int k = 0; k < 2; k++) pulse(1, 3, 3);
        cyc(2);
        check("R8", int'(count), c0 + 3, "inverted: two more falls");

        // trigger-pin sources
        tag = "R9";
        ts = 3'b111;
        cyc(2);
        c0 = int'(count);
        for (int k = 0; k < 2; k++) pulse(2, 3, 3);
        cyc(2);
        check("R9", int'(count), c0 + 2, "trigger in edge mode");
        ece = 1; sms = 3'b101; ts = 3'b101;
        cyc(2);
        c0 = int'(count);
        for (int k = 0; k < 3; k++) pulse(2, 3, 3);
        cyc(2);
        check("R9", int'(count), c0 + 3, "trigger clock with ece");
        sms = 3'b111;
        c0 = int'(count);
        for (int k = 0; k < 2; k++) pulse(0, 3, 3);
        cyc(2);
        check("R9", int'(count), c0, "ece overrides input-1 edges");
        ece = 0;

        // filter window
        tag = "R10";
        ti1_flt = 4'd3;
        cyc(3);
        c0 = int'(count);
        pulse(0, 3, 8);
        check("R10", int'(count), c0, "3-clock pulse rejected by code 3");
        pulse(0, 4, 8);
        check("R10", int'(count), c0 + 1, "4-clock pulse accepted by code 3");
        ti1_in = 1;
        cyc(4);
        check("R10", int'(count), c0 + 1, "no step before level settles");
        cyc(1);
        check("R10", int'(count), c0 + 2, "step one clock after level");
        ti1_in = 0;
        cyc(8);
        ti1_flt = 0;

        // codes that give no ticks
        tag = "R11";
        sms = 3'b100;
        cyc(2);
        c0 = int'(count);
        cyc(5);
        check("R11", int'(count), c0, "unused mode code");
        sms = 3'b111; ts = 3'b010;
        cyc(2);
        c0 = int'(count);
        pulse(0, 3, 3); pulse(1, 3, 3); pulse(2, 3, 3);
        cyc(2);
        check("R11", int'(count), c0, "unused trigger code");

        cyc(2);
        finish_up();
    end

endmodule